// File: doc/BRIEF.md
# Capture Register Bank with Full Flags

The bank snapshots a running timer count and its prescaler setting into four capture registers when either of two capture triggers pulses. The four registers are organised as two pairs, and each pair behaves as a two-deep stack. A fresh capture goes into the pair's newer register, and any unread value already there moves down into the older register. Every register carries a full flag that marks an unread value.

A capture into a pair whose two registers are both full is dropped, and a sticky lost flag records the drop. Continuous capture mode changes this: the capture always lands and the oldest value is overwritten. The bank also drives a same-cycle request that clears the external timer when a capture occurs, and it decodes a two-bit clear policy to decide when. Software reads the registers one at a time through a simple read port. It can also read an extended word that walks the full registers through a rotating pointer and carries the lost flag.

Top module: `capture_bank`

## Requirements
- R1: After reset every full flag, the extended pointer and the lost flag are 0, and every register word reads 0 apart from the slice field of the extended word.
- R2: A register read (rd_addr 0..3) returns the timer value in bits 14:0, the prescaler value in bits 18:16 and the full flag in bit 20, with every other bit 0. When rd_en is low, rd_data is 0.
- R3: Pair A uses register 1 as its newer entry and register 0 as its older one. Pair B uses register 2 as newer and register 3 as older. A capture writes the newer register and sets its flag. If the newer register held an unread value, that value and its flag move into the older register first.
- R4: With cont_cap low, a capture into a pair whose two registers are both full changes neither register and sets the lost flag.
- R5: With cont_cap high, every capture is stored, the older value is overwritten, and the lost flag is not set.
- R6: With route_all low, trig0 feeds pair A and trig1 feeds pair B. With route_all high, trig1 feeds both pairs with the same value and trig0 has no effect.
- R7: timer_clr is high in the same cycle as the trigger. With route_all low, clr_mode 2'b10 clears on trig0, 2'b01 clears on trig1, 2'b11 clears on either and 2'b00 never clears. With route_all high, timer_clr follows trig1 whatever clr_mode is.
- R8: Reading register i clears only the full flag of register i.
- R9: With ext_mode high, an extended read also clears the flag of the register the pointer selects. With ext_mode low, an extended read leaves every flag unchanged.
- R10: The extended read (rd_addr 4) returns the selected register's value in bits 14:0 and its prescaler in bits 18:16. It also returns the pointer in bits 21:20, SLICE_ID in bits 23:22, that register's full flag in bit 24 and the lost flag in bit 25.
- R11: After each extended read, the pointer moves to the first full register found in the order ptr+1, ptr+2, ptr+3 (modulo 4), judged after this read's own clear. If none of these is full, the pointer moves to ptr+1.
- R12: An extended read clears the lost flag. A drop in the same cycle sets it again, and the read itself still shows the old value.
- R13: When a read and a capture hit the same cycle, the read returns the value from before the edge. The read's flag clear takes effect before the capture rules are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | TW | Timer count to capture |
| presc_val | input | PW | Prescaler value to capture |
| trig0 | input | 1 | Capture trigger 0, one-cycle pulse |
| trig1 | input | 1 | Capture trigger 1, one-cycle pulse |
| route_all | input | 1 | 1: trig1 feeds both pairs |
| cont_cap | input | 1 | 1: capture ignores full flags |
| clr_mode | input | 2 | Timer clear policy |
| ext_mode | input | 1 | 1: extended read clears the selected flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | 0..3 register, 4 extended word |
| rd_data | output | 32 | Read word, valid in the strobe cycle |
| timer_clr | output | 1 | Timer clear request |

## Verification
rd_data and timer_clr are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and compares these outputs one nanosecond later, before the next rising edge. A capture, a flag clear, a pointer move or a lost-flag change takes effect at that next rising edge. Each of these results is therefore checked through a read issued in a later cycle, never in the cycle that caused it.

// File: rtl/capture_bank.sv
`timescale 1ns/1ps
module capture_bank #(
  parameter int TW = 15,
  parameter int PW = 3,
  parameter logic [1:0] SLICE_ID = 2'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [PW-1:0] presc_val,
  input  logic          trig0,
  input  logic          trig1,
  input  logic          route_all,
  input  logic          cont_cap,
  input  logic [1:0]    clr_mode,
  input  logic          ext_mode,
  input  logic          rd_en,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          timer_clr
);
  localparam int PSC_LSB = 16;
  localparam int FULL_B  = 20;
  localparam int PTR_LSB = 20;
  localparam int SLC_LSB = 22;
  localparam int EFULL_B = 24;
  localparam int LOST_B  = 25;
  localparam int NREG    = 4;

  logic [TW-1:0] val_q [NREG];
  logic [PW-1:0] psc_q [NREG];
  logic [TW-1:0] val_d [NREG];
  logic [PW-1:0] psc_d [NREG];
  logic [NREG-1:0] full_q, full_d, rd_hit, f_clr;
  logic [1:0] ptr_q, ptr_d, o_i, n_i;
  logic lost_q, drop, hit;

  wire ext_rd = rd_en && (rd_addr == 3'd4);

  always_comb
    for (int i = 0; i < NREG; i++)
      rd_hit[i] = (rd_en && (rd_addr == 3'(i))) || (ext_rd && ext_mode && (ptr_q == 2'(i)));

  assign f_clr = full_q & ~rd_hit;

  assign timer_clr = route_all ? trig1 : ((trig0 & clr_mode[1]) | (trig1 & clr_mode[0]));

  always_comb begin
    val_d  = val_q;
    psc_d  = psc_q;
    full_d = f_clr;
    drop   = 1'b0;
    o_i    = 2'd0;
    n_i    = 2'd1;
    hit    = 1'b0;
    for (int p = 0; p < 2; p++) begin
      o_i = (p == 0) ? 2'd0 : 2'd3;
      n_i = (p == 0) ? 2'd1 : 2'd2;
      hit = (p == 0) ? (route_all ? trig1 : trig0) : trig1;
      if (hit) begin
        if (!cont_cap && f_clr[o_i] && f_clr[n_i]) drop = 1'b1;
        else begin
          if (f_clr[n_i]) begin
            val_d[o_i]  = val_q[n_i];
            psc_d[o_i]  = psc_q[n_i];
            full_d[o_i] = 1'b1;
          end
          val_d[n_i]  = timer_val;
          psc_d[n_i]  = presc_val;
          full_d[n_i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ext_rd) begin
      ptr_d = ptr_q + 2'd1;
      for (int k = 3; k >= 1; k--)
        if (f_clr[2'(ptr_q + 2'(k))]) ptr_d = 2'(ptr_q + 2'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        val_q[i] <= '0;
        psc_q[i] <= '0;
      end
      full_q <= '0;
      ptr_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      psc_q  <= psc_d;
      full_q <= full_d;
      ptr_q  <= ptr_d;
      lost_q <= drop | (lost_q & ~ext_rd);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (!rd_addr[2]) begin
        rd_data = 32'(val_q[rd_addr[1:0]]) | (32'(psc_q[rd_addr[1:0]]) << PSC_LSB);
        rd_data[FULL_B] = full_q[rd_addr[1:0]];
      end else if (rd_addr == 3'd4) begin
        rd_data = 32'(val_q[ptr_q]) | (32'(psc_q[ptr_q]) << PSC_LSB)
                | (32'(ptr_q) << PTR_LSB) | (32'(SLICE_ID) << SLC_LSB);
        rd_data[EFULL_B] = full_q[ptr_q];
        rd_data[LOST_B]  = lost_q;
      end
    end
  end
endmodule

// File: rtl/capture_bank_chk.sv
`timescale 1ns/1ps
module capture_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig0,
  input logic       trig1,
  input logic       route_all,
  input logic       cont_cap,
  input logic       ext_mode,
  input logic       rd_en,
  input logic [2:0] rd_addr,
  input logic       timer_clr,
  input logic [3:0] full_q,
  input logic       lost_q
);
  a_r7_clr_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |-> (trig0 || trig1));

  a_r7_alt_always_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (route_all && trig1) |-> timer_clr);

  a_r4_drop_sets_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (trig0 && !route_all && !cont_cap && full_q[0] && full_q[1] && !rd_en) |=> lost_q);

  a_r5_cont_always_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (trig0 && !route_all && cont_cap) |=> full_q[1]);

  a_r9_normal_ext_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd4 && !ext_mode && !trig0 && !trig1) |=> (full_q == $past(full_q)));

  a_r12_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !(rd_en && rd_addr == 3'd4)) |=> lost_q);
endmodule

bind capture_bank capture_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig0(trig0), .trig1(trig1),
  .route_all(route_all), .cont_cap(cont_cap), .ext_mode(ext_mode),
  .rd_en(rd_en), .rd_addr(rd_addr), .timer_clr(timer_clr),
  .full_q(full_q), .lost_q(lost_q)
);

// File: tb/tb_capture_bank.sv
`timescale 1ns/1ps
module tb_capture_bank;
  localparam logic [1:0] SLC = 2'd2;

  logic clk = 0, rst_n = 0;
  logic [14:0] timer_val = '0;
  logic [2:0] presc_val = '0;
  logic trig0 = 0, trig1 = 0, route_all = 0, cont_cap = 0, ext_mode = 0, rd_en = 0;
  logic [1:0] clr_mode = 2'b10;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic timer_clr;
  int tests = 0, fails = 0;

  capture_bank #(.TW(15), .PW(3), .SLICE_ID(SLC)) dut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .presc_val(presc_val),
    .trig0(trig0), .trig1(trig1), .route_all(route_all), .cont_cap(cont_cap),
    .clr_mode(clr_mode), .ext_mode(ext_mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .timer_clr(timer_clr));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] wi(input logic f, input logic [2:0] p, input logic [14:0] v);
    return {11'd0, f, 1'b0, p, 1'b0, v};
  endfunction

  function automatic logic [31:0] we(input logic l, input logic f, input logic [1:0] ptr,
                                     input logic [2:0] p, input logic [14:0] v);
    return {6'd0, l, f, SLC, ptr, 1'b0, p, 1'b0, v};
  endfunction

  // {trig0, trig1, rd_en, rd_addr, timer, exp timer_clr, exp rd_data}; clr_mode 10, normal routing
  localparam logic [53:0] TBL [12] = '{
    {1'b1, 1'b0, 1'b0, 3'd0, 15'h11, 1'b1, 32'h0},
    {1'b1, 1'b0, 1'b0, 3'd0, 15'h22, 1'b1, 32'h0},
    {1'b1, 1'b0, 1'b0, 3'd0, 15'h33, 1'b1, 32'h0},
    {1'b0, 1'b0, 1'b1, 3'd0, 15'h0,  1'b0, wi(1'b1, 3'd1, 15'h11)},
    {1'b0, 1'b0, 1'b1, 3'd1, 15'h0,  1'b0, wi(1'b1, 3'd2, 15'h22)},
    {1'b0, 1'b0, 1'b1, 3'd1, 15'h0,  1'b0, wi(1'b0, 3'd2, 15'h22)},
    {1'b0, 1'b1, 1'b0, 3'd0, 15'h44, 1'b0, 32'h0},
    {1'b0, 1'b0, 1'b1, 3'd2, 15'h0,  1'b0, wi(1'b1, 3'd4, 15'h44)},
    {1'b0, 1'b0, 1'b1, 3'd3, 15'h0,  1'b0, 32'h0},
    {1'b0, 1'b1, 1'b1, 3'd2, 15'h55, 1'b0, wi(1'b0, 3'd4, 15'h44)},
    {1'b0, 1'b0, 1'b1, 3'd3, 15'h0,  1'b0, 32'h0},
    {1'b0, 1'b0, 1'b1, 3'd2, 15'h0,  1'b0, wi(1'b1, 3'd5, 15'h55)}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t0, input logic t1, input logic rd, input logic [2:0] a,
                      input logic [14:0] tv, input logic ck_rd, input logic [31:0] erd,
                      input logic ck_clr, input logic eclr, input string req);
    @(negedge clk);
    trig0 = t0; trig1 = t1; rd_en = rd; rd_addr = a; timer_val = tv; presc_val = tv[2:0];
    #1;
    if (ck_rd) chk(rd_data === erd, req, rd_data, erd);
    if (ck_clr) chk(timer_clr === eclr, req, 32'(timer_clr), 32'(eclr));
    @(posedge clk);
    #1;
    trig0 = 0; trig1 = 0; rd_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    step(1'b0, 1'b0, 1'b1, a, 15'h0, 1'b1, e, 1'b0, 1'b0, req);
  endtask

  task automatic cap(input logic t0, input logic t1, input logic [14:0] tv);
    step(t0, t1, 1'b0, 3'd0, tv, 1'b0, 32'h0, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string tags [12] = '{"R6", "R3", "R4", "R3", "R8", "R8", "R6", "R2", "R3", "R13", "R13", "R13"};
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(3'(a), 32'h0, "R1");
    rd(3'd4, we(1'b0, 1'b0, 2'd0, 3'd0, 15'h0), "R1");

    for (int i = 0; i < 12; i++) begin
      logic t0, t1, r, ec;
      logic [2:0] a;
      logic [14:0] tv;
      logic [31:0] ew;
      {t0, t1, r, a, tv, ec, ew} = TBL[i];
      step(t0, t1, r, a, tv, 1'b1, ew, 1'b1, ec, tags[i]);
    end

    // R5 continuous capture overwrites, no loss; R9 normal mode ext read keeps flags
    do_reset();
    cont_cap = 1;
    cap(1'b1, 1'b0, 15'h101);
    cap(1'b1, 1'b0, 15'h102);
    cap(1'b1, 1'b0, 15'h103);
    rd(3'd4, we(1'b0, 1'b1, 2'd0, 3'd2, 15'h102), "R5");
    rd(3'd0, wi(1'b1, 3'd2, 15'h102), "R9");
    rd(3'd1, wi(1'b1, 3'd3, 15'h103), "R5");
    cont_cap = 0;

    // R6 alternate routing
    do_reset();
    route_all = 1; clr_mode = 2'b00;
    step(1'b1, 1'b0, 1'b0, 3'd0, 15'h0aa, 1'b0, 32'h0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 3'd0, 15'h0bb, 1'b0, 32'h0, 1'b1, 1'b1, "R7");
    rd(3'd0, 32'h0, "R6");
    rd(3'd1, wi(1'b1, 3'd3, 15'h0bb), "R6");
    rd(3'd2, wi(1'b1, 3'd3, 15'h0bb), "R6");
    rd(3'd3, 32'h0, "R6");
    route_all = 0;

    // R7 clear policy encodings
    do_reset();
    clr_mode = 2'b01;
    step(1'b1, 1'b0, 1'b0, 3'd0, 15'h1, 1'b0, 32'h0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 3'd0, 15'h2, 1'b0, 32'h0, 1'b1, 1'b1, "R7");
    clr_mode = 2'b11;
    step(1'b1, 1'b0, 1'b0, 3'd0, 15'h3, 1'b0, 32'h0, 1'b1, 1'b1, "R7");
    clr_mode = 2'b00;
    step(1'b0, 1'b1, 1'b0, 3'd0, 15'h4, 1'b0, 32'h0, 1'b1, 1'b0, "R7");
    clr_mode = 2'b10;

    // R9 R10 R11 R12 extended read walk
    do_reset();
    ext_mode = 1;
    cap(1'b1, 1'b0, 15'h11);
    cap(1'b0, 1'b1, 15'h22);
    cap(1'b1, 1'b0, 15'h33);
    cap(1'b1, 1'b0, 15'h44);
    rd(3'd4, we(1'b1, 1'b1, 2'd0, 3'd1, 15'h11), "R10");
    rd(3'd4, we(1'b0, 1'b1, 2'd1, 3'd3, 15'h33), "R12");
    rd(3'd4, we(1'b0, 1'b1, 2'd2, 3'd2, 15'h22), "R11");
    rd(3'd4, we(1'b0, 1'b0, 2'd3, 3'd0, 15'h0), "R11");
    rd(3'd0, wi(1'b0, 3'd1, 15'h11), "R9");
    cap(1'b0, 1'b1, 15'h55);
    rd(3'd4, we(1'b0, 1'b0, 2'd0, 3'd1, 15'h11), "R11");
    rd(3'd4, we(1'b0, 1'b1, 2'd2, 3'd5, 15'h55), "R11");

    // R12 drop in the same cycle as an extended read
    do_reset();
    cap(1'b0, 1'b1, 15'h61);
    cap(1'b0, 1'b1, 15'h62);
    step(1'b0, 1'b1, 1'b1, 3'd4, 15'h63, 1'b1, we(1'b0, 1'b0, 2'd0, 3'd0, 15'h0), 1'b0, 1'b0, "R12");
    rd(3'd4, we(1'b1, 1'b1, 2'd2, 3'd2, 15'h62), "R12");
    rd(3'd3, wi(1'b1, 3'd1, 15'h61), "R4");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule